// File: doc/BRIEF.md
# Lockstep Serial Transmit Lane

This block is one lane of a serial transmitter. Its shift logic runs on a timing clock at twice the serial clock rate. The lane passes that double-rate clock to a dedicated output, which a receiver uses to time its sampling. A second input, which runs at the serial clock rate, goes straight through to the serial clock pin. On a start request the lane captures a data word and shifts it out on its data pin, most significant bit first. Each bit is held for one full serial clock period, which is two double-rate periods.

A transfer starts either from a local start bit that software writes, or from a shared external start line. One designated master lane drives that shared line from its broadcast bit, so several lanes can begin shifting on the same edge. The broadcast bit has no effect in every other lane. Both starts are edge-detected, and a busy flag covers the whole frame. A request that arrives while the lane is busy is dropped.

Top module: `sync_tx_lane`

## Requirements
- R1: `clkX2Out` always equals the `clkX2` input.
- R2: `sclkOut` always equals the `sclkIn` input.
- R3: A 0-to-1 change on `swStart` while `busy` is low starts a transfer on the next rising `clkX2` edge. That edge captures `txData`, and `busy` is high after it.
- R4: A 0-to-1 change on `extStart` while `busy` is low starts a transfer in the same way as R3.
- R5: `sdo` presents the captured word most significant bit first. Each bit is held for two `clkX2` periods, and `sdo` changes only on every second rising edge after the start edge.
- R6: After a start, `busy` stays high for exactly 2*WIDTH `clkX2` periods (WIDTH defaults to 16) and then falls. `sdo` is 0 whenever `busy` is low.
- R7: A start input held high launches exactly one transfer. No new transfer follows it until the input has gone low and risen again.
- R8: Start edges on either input that occur while `busy` is high are ignored. They launch no later transfer and do not change the word being shifted.
- R9: `bcastOut` equals `bcastBit` when the parameter IS_MASTER is 1. When IS_MASTER is 0, `bcastOut` is held at 0 whatever `bcastBit` does.
- R10: While `rstN` is low and after it is released, `busy` and `sdo` are 0 until a start edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkX2 | input | 1 | Timing clock at twice the serial clock rate; clocks the lane |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Clock at the serial rate, passed through to the pin |
| swStart | input | 1 | Local software start bit |
| extStart | input | 1 | Shared start line driven by the master lane |
| bcastBit | input | 1 | This lane's broadcast start register bit |
| txData | input | WIDTH | Word captured when a transfer starts |
| clkX2Out | output | 1 | Forwarded double-rate clock for the receiver |
| sclkOut | output | 1 | Forwarded serial clock |
| sdo | output | 1 | Serial data out, MSB first |
| busy | output | 1 | High for the duration of a frame |
| bcastOut | output | 1 | Broadcast start to other lanes; driven only in the master lane |

## Verification
The hardest case to reach from the ports is a start edge that lands in the middle of a frame, because it must leave both the frame length and the bits in flight untouched. To produce it, the stimulus counts `clkX2` edges from a launch. Part way through the frame it makes a fresh low-to-high step on the local start and then on the external start, each carrying a different data word. The scoreboard then demands that only the original word appears, with exactly one busy window, and that the lane stays idle afterwards. A second case holds the local start high across the end of a frame, to show that the level alone never starts a second frame.

// File: rtl/sync_tx_lane_pkg.sv
package sync_tx_lane_pkg;
  typedef struct packed {
    logic load;    // capture txData into the shifter
    logic shift;   // advance to the next bit
    logic active;  // frame in progress
  } txStrobe_t;
endpackage

// File: rtl/sync_tx_lane_ctrl.sv
module sync_tx_lane_ctrl
  import sync_tx_lane_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic      clkX2,
  input  logic      rstN,
  input  logic      swStart,
  input  logic      extStart,
  output txStrobe_t strobe
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

  logic            swQ, extQ;
  logic            busyQ;
  logic            phaseQ;
  logic [CNT_W-1:0] bitCnt;
  logic            startReq;
  logic            lastBit;

  assign startReq = (swStart & ~swQ) | (extStart & ~extQ);
  assign lastBit  = (bitCnt == LAST_IDX);

  always_ff @(posedge clkX2 or negedge rstN) begin
    if (!rstN) begin
      swQ    <= 1'b0;
      extQ   <= 1'b0;
      busyQ  <= 1'b0;
      phaseQ <= 1'b0;
      bitCnt <= '0;
    end else begin
      swQ  <= swStart;
      extQ <= extStart;
      if (!busyQ) begin
        if (startReq) begin
          busyQ  <= 1'b1;
          phaseQ <= 1'b0;
          bitCnt <= '0;
        end
      end else begin
        phaseQ <= ~phaseQ;
        if (phaseQ) begin
          if (lastBit) busyQ <= 1'b0;
          else         bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load   = ~busyQ & startReq;
    strobe.shift  = busyQ & phaseQ & ~lastBit;
    strobe.active = busyQ;
  end
endmodule

// File: rtl/sync_tx_lane_dp.sv
module sync_tx_lane_dp
  import sync_tx_lane_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clkX2,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  input  logic [WIDTH-1:0] txData,
  output logic             sdo
);
  logic [WIDTH-1:0] shiftReg;

  generate
    if (WIDTH > 1) begin : gWide
      always_ff @(posedge clkX2 or negedge rstN) begin
        if (!rstN)             shiftReg <= '0;
        else if (strobe.load)  shiftReg <= txData;
        else if (strobe.shift) shiftReg <= {shiftReg[WIDTH-2:0], 1'b0};
      end
    end else begin : gSingle
      always_ff @(posedge clkX2 or negedge rstN) begin
        if (!rstN)            shiftReg <= '0;
        else if (strobe.load) shiftReg <= txData;
      end
    end
  endgenerate

  assign sdo = strobe.active & shiftReg[WIDTH-1];
endmodule

// File: rtl/sync_tx_lane.sv
module sync_tx_lane
  import sync_tx_lane_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic             clkX2,
  input  logic             rstN,
  input  logic             sclkIn,
  input  logic             swStart,
  input  logic             extStart,
  input  logic             bcastBit,
  input  logic [WIDTH-1:0] txData,
  output logic             clkX2Out,
  output logic             sclkOut,
  output logic             sdo,
  output logic             busy,
  output logic             bcastOut
);
  txStrobe_t strobe;

  sync_tx_lane_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clkX2   (clkX2),
    .rstN    (rstN),
    .swStart (swStart),
    .extStart(extStart),
    .strobe  (strobe)
  );

  sync_tx_lane_dp #(.WIDTH(WIDTH)) dp_i (
    .clkX2 (clkX2),
    .rstN  (rstN),
    .strobe(strobe),
    .txData(txData),
    .sdo   (sdo)
  );

  assign clkX2Out = clkX2;
  assign sclkOut  = sclkIn;
  assign busy     = strobe.active;

  generate
    if (IS_MASTER) begin : gMaster
      assign bcastOut = bcastBit;
    end else begin : gFollower
      assign bcastOut = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sync_tx_lane_chk.sv
module sync_tx_lane_chk #(
  parameter int WIDTH = 16
) (
  input logic clkX2,
  input logic rstN,
  input logic swStart,
  input logic extStart,
  input logic sdo,
  input logic busy
);
  localparam int FRAME = 2 * WIDTH;
  localparam int CW    = $clog2(FRAME + 1);

  logic          swSeen, extSeen;
  logic [CW-1:0] busyCnt;

  always_ff @(posedge clkX2 or negedge rstN) begin
    if (!rstN) begin
      swSeen  <= 1'b0;
      extSeen <= 1'b0;
      busyCnt <= '0;
    end else begin
      swSeen  <= swStart;
      extSeen <= extStart;
      busyCnt <= busy ? busyCnt + 1'b1 : '0;
    end
  end

  assert_sw_launch_R3: assert property (@(posedge clkX2) disable iff (!rstN)
    (!busy && swStart && !swSeen) |=> busy);

  assert_ext_launch_R4: assert property (@(posedge clkX2) disable iff (!rstN)
    (!busy && extStart && !extSeen) |=> busy);

  assert_bit_hold_R5: assert property (@(posedge clkX2) disable iff (!rstN)
    (busy && busyCnt[0]) |-> $stable(sdo));

  assert_frame_hold_R6: assert property (@(posedge clkX2) disable iff (!rstN)
    (busy && busyCnt < CW'(FRAME - 1)) |=> busy);

  assert_frame_end_R6: assert property (@(posedge clkX2) disable iff (!rstN)
    (busy && busyCnt == CW'(FRAME - 1)) |=> !busy);

  assert_idle_low_R6: assert property (@(posedge clkX2) disable iff (!rstN)
    !busy |-> !sdo);
endmodule

bind sync_tx_lane sync_tx_lane_chk #(.WIDTH(WIDTH)) chk_i (
  .clkX2   (clkX2),
  .rstN    (rstN),
  .swStart (swStart),
  .extStart(extStart),
  .sdo     (sdo),
  .busy    (busy)
);

// File: tb/sync_tx_lane_tb_top.sv
module sync_tx_lane_tb_top;
  localparam int WIDTH = 16;

  logic clkX2 = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0;
  logic swStart = 1'b0, extStart = 1'b0, bcastBit = 1'b0;
  logic [WIDTH-1:0] txData = '0;
  logic clkX2Out, sclkOut, sdo, busy, bcastOut;
  logic fClkOut, fSclkOut, fSdo, fBusy, fBcastOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit expBits[$];
  int halfCnt = 0;
  bit prevBusy = 1'b0;

  always #5 clkX2 = ~clkX2;
  always @(posedge clkX2) sclkIn <= ~sclkIn;

  sync_tx_lane #(.WIDTH(WIDTH), .IS_MASTER(1'b1)) dut_i (
    .clkX2(clkX2), .rstN(rstN), .sclkIn(sclkIn), .swStart(swStart),
    .extStart(extStart), .bcastBit(bcastBit), .txData(txData),
    .clkX2Out(clkX2Out), .sclkOut(sclkOut), .sdo(sdo), .busy(busy),
    .bcastOut(bcastOut));

  sync_tx_lane #(.WIDTH(WIDTH), .IS_MASTER(1'b0)) follower_i (
    .clkX2(clkX2), .rstN(rstN), .sclkIn(sclkIn), .swStart(1'b0),
    .extStart(1'b0), .bcastBit(bcastBit), .txData('0),
    .clkX2Out(fClkOut), .sclkOut(fSclkOut), .sdo(fSdo), .busy(fBusy),
    .bcastOut(fBcastOut));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares sdo in the second half of each bit and the busy length.
  always @(negedge clkX2) begin
    cycles++;
    if (busy) begin
      if (halfCnt[0]) begin
        if (expBits.size() == 0) check("R8 unexpected bit", 32'(sdo), 32'h0);
        else check("R5 serial bit", 32'(sdo), 32'(expBits.pop_front()));
      end else if (halfCnt > 0) begin
        check("R5 bit boundary", 32'(sdo), 32'(expBits.size() > 0 ? expBits[0] : 1'b0));
      end
      halfCnt++;
    end else begin
      if (prevBusy) check("R6 busy length", 32'(halfCnt), 32'(2 * WIDTH));
      if (rstN) check("R6 idle sdo", 32'(sdo), 32'h0);
      halfCnt = 0;
    end
    prevBusy = busy;
  end

  always @(negedge clkX2) begin
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic pushWord(input logic [WIDTH-1:0] w);
    for (int i = WIDTH - 1; i >= 0; i--) expBits.push_back(w[i]);
  endtask

  task automatic launch(input logic [WIDTH-1:0] w, input bit useExt, input bit hold);
    @(negedge clkX2);
    txData = w;
    if (useExt) extStart = 1'b1; else swStart = 1'b1;
    pushWord(w);
    @(negedge clkX2);
    check(useExt ? "R4 ext launch" : "R3 sw launch", 32'(busy), 32'h1);
    if (!hold) begin swStart = 1'b0; extStart = 1'b0; end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clkX2);
  endtask

  initial begin
    repeat (3) @(negedge clkX2);
    check("R10 reset busy", 32'(busy), 32'h0);
    check("R10 reset sdo", 32'(sdo), 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clkX2);
    check("R10 idle after reset", 32'(busy), 32'h0);

    // Clock passthroughs, sampled at both clock levels.
    for (int i = 0; i < 4; i++) begin
      @(posedge clkX2); #2;
      check("R1 clkX2Out high", 32'(clkX2Out), 32'h1);
      check("R2 sclkOut", 32'(sclkOut), 32'(sclkIn));
      @(negedge clkX2); #2;
      check("R1 clkX2Out low", 32'(clkX2Out), 32'h0);
      check("R2 sclkOut", 32'(sclkOut), 32'(sclkIn));
    end

    launch(16'hA5C3, 1'b0, 1'b0); waitIdle();
    launch(16'h8001, 1'b0, 1'b0); waitIdle();
    launch(16'hFFFF, 1'b1, 1'b0); waitIdle();
    launch(16'h3C96, 1'b1, 1'b0); waitIdle();

    // R7: hold the local start high across the frame end.
    launch(16'h6E21, 1'b0, 1'b1); waitIdle();
    repeat (8) begin
      @(negedge clkX2);
      check("R7 no relaunch while held", 32'(busy), 32'h0);
    end
    swStart = 1'b0;

    // R8: fresh start edges on both inputs mid-frame.
    launch(16'h4B1D, 1'b0, 1'b0);
    repeat (5) @(negedge clkX2);
    txData = 16'hFFFF; swStart = 1'b1;
    @(negedge clkX2); swStart = 1'b0; extStart = 1'b1; txData = 16'h0F0F;
    @(negedge clkX2); extStart = 1'b0;
    waitIdle();
    repeat (6) begin
      @(negedge clkX2);
      check("R8 no late launch", 32'(busy), 32'h0);
    end
    check("R8 queue drained", 32'(expBits.size()), 32'h0);

    // R9: broadcast bit only leaves the master lane.
    bcastBit = 1'b1; #1;
    check("R9 master bcast high", 32'(bcastOut), 32'h1);
    check("R9 follower bcast", 32'(fBcastOut), 32'h0);
    bcastBit = 1'b0; #1;
    check("R9 master bcast low", 32'(bcastOut), 32'h0);
    check("R9 follower busy", 32'(fBusy), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule